// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Dirty Write-Back

This block holds recently used virtual-to-physical page translations in a small fully associative array. A requester presents a virtual address with an access kind (read, write or execute). In the same cycle the block answers with a hit and the physical address, a miss, or a protection fault. On a miss, an external walker fetches the mapping and installs it through the refill port. The block picks the slot: the lowest-numbered empty slot if there is one, otherwise the least recently used slot.

Each slot records whether its page has been written. When a written ("dirty") slot is overwritten by a refill, the block puts its page numbers on the write-back port for one cycle, so the page table entry can be marked modified. A flush request walks every slot through a small state machine and emits each dirty slot on the same port. It then invalidates the whole array in a single cycle.

The control has three states. ST_READY serves lookups and refills, and goes to ST_SCAN when flush is asserted. ST_SCAN visits one slot per cycle in ascending order and goes to ST_CLEAR after the last slot. ST_CLEAR drops every valid and dirty bit and returns to ST_READY.

Top module: `tlb_fa_dirty`

## Requirements
- R1: After reset no slot is valid, `ready` is 1, `wb_valid` is 0 and every lookup reports a miss.
- R2: A lookup that matches a valid slot with sufficient rights raises `lk_hit` in the same cycle as the request, with `lk_paddr` equal to the slot's physical page number concatenated with the untouched 12 low address bits.
- R3: A lookup whose 20-bit virtual page number matches no valid slot raises `lk_miss` only.
- R4: Access kind encoding: 0 = read needs R, 1 = write needs W, 2 = execute needs X. A matching slot that lacks the needed right raises `lk_fault` only. At most one of hit, miss and fault is high.
- R5: A write that hits sets that slot's dirty bit. A write that faults leaves the dirty bit clear.
- R6: A refill goes to the lowest-numbered invalid slot. If all slots are valid, it goes to the least recently used slot, where successful hits and refills count as uses.
- R7: When a refill overwrites a valid dirty slot, `wb_valid` is high for one cycle starting the cycle after the refill, carrying the old virtual and physical page numbers with `wb_dirty` = 1. Overwriting a clean slot produces nothing on the write-back port.
- R8: A flush drops `ready` for ENTRIES+1 cycles. It emits every valid dirty slot on the write-back port, one per cycle in ascending slot order, and afterwards every lookup misses.
- R9: While `ready` is low, lookups get no hit, miss or fault response.
- R10: If two valid slots hold the same virtual page number, the lowest-numbered one answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | Translation found and allowed |
| lk_miss | output | 1 | No valid slot matches |
| lk_fault | output | 1 | Slot matches but rights forbid the access |
| lk_paddr | output | 32 | Physical address (valid with lk_hit) |
| rf_valid | input | 1 | Install a translation |
| rf_vpn | input | 20 | Virtual page number to install |
| rf_ppn | input | 20 | Physical page number to install |
| rf_r | input | 1 | Read right |
| rf_w | input | 1 | Write right |
| rf_x | input | 1 | Execute right |
| flush | input | 1 | Write back dirty slots and invalidate all |
| ready | output | 1 | Block is in ST_READY |
| wb_valid | output | 1 | Dirty slot write-back pulse |
| wb_vpn | output | 20 | Virtual page number of the written-back slot |
| wb_ppn | output | 20 | Physical page number of the written-back slot |
| wb_dirty | output | 1 | Dirty flag of the written-back slot |

## Verification
On every cycle, the assertions check the following:
- the response is exclusive, and there is no response while busy;
- the page offset passes through on a hit;
- a write hit leaves a dirty bit behind one cycle later;
- the flush moves from ST_READY to ST_SCAN, and from ST_CLEAR back to ST_READY with an empty array.

Only the bench scenarios can show the rest:
- LRU victim choice after a long series of touches;
- that a faulting write leaves no dirty bit behind, seen as a missing write-back;
- the order and content of write-back pulses during a flush;
- the length of the busy window;
- the priority between duplicate tags.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_SCAN  = 2'd1,
        ST_CLEAR = 2'd2
    } tlb_state_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic             valid_vec [ENTRIES],
    input  logic [VPN_W-1:0] tags      [ENTRIES],
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [ENTRIES-1:0] eq;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign eq[g] = valid_vec[g] && (tags[g] == vpn);
        end
    endgenerate

    // lowest index wins: scan downward so the last write is the smallest index
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             valid_vec [ENTRIES],
    input  logic [IDX_W-1:0] ages      [ENTRIES],
    output logic [IDX_W-1:0] idx
);
    logic             have_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        old_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
            if (ages[i] == IDX_W'(ENTRIES - 1)) begin
                old_idx = IDX_W'(i);
            end
        end
        idx = have_free ? free_idx : old_idx;
    end
endmodule

// File: rtl/tlb_fa_dirty.sv
module tlb_fa_dirty
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PPN_W   = 20,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PPN_W + OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_acc,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic             rf_r,
    input  logic             rf_w,
    input  logic             rf_x,
    input  logic             flush,
    output logic             ready,
    output logic             wb_valid,
    output logic [VPN_W-1:0] wb_vpn,
    output logic [PPN_W-1:0] wb_ppn,
    output logic             wb_dirty
);
    tlb_state_e       state_q, state_d;
    logic [IDX_W-1:0] scan_q, scan_d;

    logic             valid_q [ENTRIES];
    logic             dirty_q [ENTRIES];
    logic             rd_q    [ENTRIES];
    logic             wr_q    [ENTRIES];
    logic             ex_q    [ENTRIES];
    logic [VPN_W-1:0] tag_q   [ENTRIES];
    logic [PPN_W-1:0] ppn_q   [ENTRIES];
    logic [IDX_W-1:0] age_q   [ENTRIES];

    logic             wb_valid_q, wb_dirty_q;
    logic [VPN_W-1:0] wb_vpn_q;
    logic [PPN_W-1:0] wb_ppn_q;

    logic             m_any;
    logic [IDX_W-1:0] m_idx, v_idx;
    logic             perm_ok, rf_accept, lk_update, touch_en;
    logic [IDX_W-1:0] touch_idx;

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
        .vpn(lk_vaddr[VA_W-1:OFF_W]), .valid_vec(valid_q), .tags(tag_q),
        .any(m_any), .idx(m_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid_vec(valid_q), .ages(age_q), .idx(v_idx)
    );

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            scan_q  <= '0;
        end else begin
            state_q <= state_d;
            scan_q  <= scan_d;
        end
    end

    always_comb begin
        state_d = state_q;
        scan_d  = scan_q;
        unique case (state_q)
            ST_READY: begin
                scan_d = '0;
                if (flush) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                scan_d = scan_q + 1'b1;
                if (scan_q == IDX_W'(ENTRIES - 1)) state_d = ST_CLEAR;
            end
            ST_CLEAR: state_d = ST_READY;
            default:  state_d = ST_READY;
        endcase
    end

    // output process
    always_comb begin
        ready = (state_q == ST_READY);
        unique case (acc_e'(lk_acc))
            ACC_READ:  perm_ok = rd_q[m_idx];
            ACC_WRITE: perm_ok = wr_q[m_idx];
            ACC_EXEC:  perm_ok = ex_q[m_idx];
            default:   perm_ok = 1'b0;
        endcase
        lk_hit   = ready && lk_valid && m_any && perm_ok;
        lk_fault = ready && lk_valid && m_any && !perm_ok;
        lk_miss  = ready && lk_valid && !m_any;
        lk_paddr = lk_hit ? {ppn_q[m_idx], lk_vaddr[OFF_W-1:0]} : '0;
        wb_valid = wb_valid_q;
        wb_vpn   = wb_vpn_q;
        wb_ppn   = wb_ppn_q;
        wb_dirty = wb_dirty_q;
    end

    assign rf_accept = ready && rf_valid && !flush;
    assign lk_update = lk_hit && !rf_accept;
    assign touch_en  = rf_accept || lk_update;
    assign touch_idx = rf_accept ? v_idx : m_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                valid_q[i] <= 1'b0;
                dirty_q[i] <= 1'b0;
                rd_q[i]    <= 1'b0;
                wr_q[i]    <= 1'b0;
                ex_q[i]    <= 1'b0;
                tag_q[i]   <= '0;
                ppn_q[i]   <= '0;
                age_q[i]   <= IDX_W'(i);
            end
            wb_valid_q <= 1'b0;
            wb_dirty_q <= 1'b0;
            wb_vpn_q   <= '0;
            wb_ppn_q   <= '0;
        end else begin
            wb_valid_q <= 1'b0;
            if (touch_en) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (IDX_W'(i) == touch_idx) age_q[i] <= '0;
                    else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
                end
            end
            if (lk_update && acc_e'(lk_acc) == ACC_WRITE) dirty_q[m_idx] <= 1'b1;
            if (rf_accept) begin
                if (valid_q[v_idx] && dirty_q[v_idx]) begin
                    wb_valid_q <= 1'b1;
                    wb_dirty_q <= 1'b1;
                    wb_vpn_q   <= tag_q[v_idx];
                    wb_ppn_q   <= ppn_q[v_idx];
                end
                valid_q[v_idx] <= 1'b1;
                dirty_q[v_idx] <= 1'b0;
                rd_q[v_idx]    <= rf_r;
                wr_q[v_idx]    <= rf_w;
                ex_q[v_idx]    <= rf_x;
                tag_q[v_idx]   <= rf_vpn;
                ppn_q[v_idx]   <= rf_ppn;
            end
            if (state_q == ST_SCAN && valid_q[scan_q] && dirty_q[scan_q]) begin
                wb_valid_q <= 1'b1;
                wb_dirty_q <= 1'b1;
                wb_vpn_q   <= tag_q[scan_q];
                wb_ppn_q   <= ppn_q[scan_q];
            end
            if (state_q == ST_CLEAR) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    valid_q[i] <= 1'b0;
                    dirty_q[i] <= 1'b0;
                end
            end
        end
    end

    // R4
    resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_miss, lk_fault}));

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !(lk_hit || lk_miss || lk_fault));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

    // R5
    write_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_acc == 2'd1 && !rf_accept) |=> dirty_q[$past(m_idx)]);

    // R8
    flush_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && flush) |=> state_q == ST_SCAN);

    // R8
    flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |=> (state_q == ST_READY && !valid_q[0] && !valid_q[ENTRIES-1]));
endmodule

// File: tb/tb_tlb_fa_dirty.sv
module tb_tlb_fa_dirty;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [31:0] lk_paddr;
    logic        rf_valid = 1'b0;
    logic [19:0] rf_vpn = '0, rf_ppn = '0;
    logic        rf_r = 1'b0, rf_w = 1'b0, rf_x = 1'b0;
    logic        flush = 1'b0;
    logic        ready, wb_valid, wb_dirty;
    logic [19:0] wb_vpn, wb_ppn;

    always #2 clk = ~clk;

    tlb_fa_dirty #(.ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
        .lk_paddr(lk_paddr), .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
        .rf_r(rf_r), .rf_w(rf_w), .rf_x(rf_x), .flush(flush), .ready(ready),
        .wb_valid(wb_valid), .wb_vpn(wb_vpn), .wb_ppn(wb_ppn), .wb_dirty(wb_dirty)
    );

    int errors = 0;
    int checks = 0;

    localparam logic [2:0] K_HIT = 3'b100, K_MISS = 3'b010, K_FAULT = 3'b001, K_NONE = 3'b000;

    logic [2:0]  kq  [$];
    logic [31:0] paq [$];
    string       rq  [$];
    logic [39:0] evq [$];
    string       erq [$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [19:0] vpn, input logic [11:0] off, input logic [1:0] acc,
                          input logic [2:0] k, input logic [19:0] ppn, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_acc = acc;
        kq.push_back(k); paq.push_back({ppn, off}); rq.push_back(req);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn, input logic r, input logic w, input logic x);
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = vpn; rf_ppn = ppn; rf_r = r; rf_w = w; rf_x = x;
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic expect_wb(input logic [19:0] vpn, input logic [19:0] ppn, input string req);
        evq.push_back({vpn, ppn}); erq.push_back(req);
    endtask

    task automatic wait_ready(output int cnt);
        cnt = 0;
        while (!ready) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    // monitor: compares design responses against the scoreboard queues
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (lk_valid && kq.size() > 0) begin
                    logic [2:0] k;
                    logic [31:0] pa;
                    string r;
                    k = kq.pop_front(); pa = paq.pop_front(); r = rq.pop_front();
                    chk({lk_hit, lk_miss, lk_fault} == k, r, 64'({lk_hit, lk_miss, lk_fault}), 64'(k));
                    if (k == K_HIT) chk(lk_paddr == pa, r, 64'(lk_paddr), 64'(pa));
                end
                if (wb_valid) begin
                    if (evq.size() == 0) begin
                        chk(1'b0, "R7 unexpected write-back", 64'({wb_vpn, wb_ppn}), 64'(0));
                    end else begin
                        logic [39:0] e;
                        string r;
                        e = evq.pop_front(); r = erq.pop_front();
                        chk({wb_vpn, wb_ppn, wb_dirty} == {e, 1'b1}, r,
                            64'({wb_vpn, wb_ppn, wb_dirty}), 64'({e, 1'b1}));
                    end
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(ready == 1'b1, "R1 ready after reset", 64'(ready), 64'(1));
        chk(wb_valid == 1'b0, "R1 no write-back after reset", 64'(wb_valid), 64'(0));
        lookup(20'h00000, 12'h000, 2'd0, K_MISS, '0, "R1 empty lookup");
        lookup(20'h00abc, 12'h123, 2'd0, K_MISS, '0, "R3 miss");

        // fill all slots with full rights; vpn i -> ppn 0x100+i
        for (int i = 0; i < N; i++) refill(20'(i), 20'(32'h100 + i), 1'b1, 1'b1, 1'b1);
        lookup(20'd5, 12'hfff, 2'd0, K_HIT, 20'h105, "R2 read hit");
        lookup(20'd17, 12'h001, 2'd2, K_HIT, 20'h111, "R2 exec hit");
        lookup(20'h00777, 12'h000, 2'd1, K_MISS, '0, "R3 miss when full");

        // R6 LRU: dirty slot 0, then touch 1..31 so slot 0 is oldest
        lookup(20'd0, 12'h040, 2'd1, K_HIT, 20'h100, "R5 write hit");
        for (int i = 1; i < N; i++) lookup(20'(i), 12'h000, 2'd0, K_HIT, 20'(32'h100 + i), "R6 touch");
        expect_wb(20'd0, 20'h100, "R7 dirty victim written back");
        refill(20'h00500, 20'h00a00, 1'b1, 1'b1, 1'b1);
        refill(20'h00501, 20'h00a01, 1'b1, 1'b1, 1'b1);
        lookup(20'd0, 12'h000, 2'd0, K_MISS, '0, "R6 LRU slot 0 replaced");
        lookup(20'd1, 12'h000, 2'd0, K_MISS, '0, "R6 next LRU slot 1 replaced");
        lookup(20'd2, 12'h000, 2'd0, K_HIT, 20'h102, "R6 slot 2 kept");
        lookup(20'h00501, 12'h0aa, 2'd0, K_HIT, 20'h00a01, "R6 new entry hit");

        // R8 flush with dirty slots 3 and 9, emitted in slot order
        lookup(20'd9, 12'h000, 2'd1, K_HIT, 20'h109, "R5 write hit 9");
        lookup(20'd3, 12'h000, 2'd1, K_HIT, 20'h103, "R5 write hit 3");
        expect_wb(20'd3, 20'h103, "R8 flush write-back slot 3");
        expect_wb(20'd9, 20'h109, "R8 flush write-back slot 9");
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        #1;
        chk(ready == 1'b0, "R8 ready drops on flush", 64'(ready), 64'(0));
        lookup(20'h00500, 12'h000, 2'd0, K_NONE, '0, "R9 no response while busy");
        wait_ready(cnt);
        lookup(20'd3, 12'h000, 2'd0, K_MISS, '0, "R8 empty after flush");
        lookup(20'h00501, 12'h000, 2'd0, K_MISS, '0, "R8 empty after flush 2");
        chk(evq.size() == 0, "R8 all flush write-backs seen", 64'(evq.size()), 64'(0));

        // R4 rights: 0x10 R only, 0x11 RW, 0x12 X only
        refill(20'h00010, 20'h00c10, 1'b1, 1'b0, 1'b0);
        refill(20'h00011, 20'h00c11, 1'b1, 1'b1, 1'b0);
        refill(20'h00012, 20'h00c12, 1'b0, 1'b0, 1'b1);
        lookup(20'h00012, 12'h000, 2'd0, K_FAULT, '0, "R4 read without R");
        lookup(20'h00010, 12'h000, 2'd1, K_FAULT, '0, "R4 write without W");
        lookup(20'h00011, 12'h000, 2'd2, K_FAULT, '0, "R4 exec without X");
        lookup(20'h00010, 12'h321, 2'd0, K_HIT, 20'h00c10, "R4 read allowed");
        lookup(20'h00012, 12'h004, 2'd2, K_HIT, 20'h00c12, "R4 exec allowed");
        lookup(20'h00011, 12'h008, 2'd1, K_HIT, 20'h00c11, "R4 write allowed");
        // R5 faulting write on 0x10 must not be written back
        expect_wb(20'h00011, 20'h00c11, "R5 only written slot flushed");
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        wait_ready(cnt);
        chk(cnt == N + 1, "R8 busy window length", 64'(cnt), 64'(N + 1));
        chk(evq.size() == 0, "R5 write-back count", 64'(evq.size()), 64'(0));

        // R10 duplicate tags: lowest slot answers
        refill(20'h00020, 20'h00d00, 1'b1, 1'b1, 1'b1);
        refill(20'h00020, 20'h00d01, 1'b1, 1'b1, 1'b1);
        lookup(20'h00020, 12'h010, 2'd0, K_HIT, 20'h00d00, "R10 lowest slot wins");

        repeat (4) @(negedge clk);
        chk(kq.size() == 0, "R2 scoreboard drained", 64'(kq.size()), 64'(0));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule